// File: doc/BRIEF.md
# Systolic Multiply-Add Chain Filter

This block is a small FIR-style datapath. It is built as a chain of two or four multiply-add stages. Samples arrive on a valid/ready stream. They march through a register chain that holds two registers per stage. Each stage multiplies its tap by its own coefficient and adds the product to the partial sum registered by the stage before it. Partial sums move one stage per clock, in the same direction as the samples. The extra sample register per stage keeps every product in step with the sum passing through. No wide adder tree is needed. The last stage's registered sum is the filter output.

The pipeline steps forward as a whole on every clock in which the output is not stalled. If no sample is offered on a stepping clock, a zero-valued bubble enters and its valid flag is low. So the output is always the weighted sum of the most recent NUM_MULT slots, with bubbles counting as zero. The output is qualified by a valid flag that has travelled down the pipeline with its sample.

Back-pressure rules:
- A result is held while `out_valid` is high and `out_ready` is low. During that time the whole pipeline freezes and `in_ready` is low.
- A sample is taken only on a clock where `in_valid` and `in_ready` are both high.
- `in_ready` does not depend on `in_valid`.

Coefficients are parallel configuration inputs. Change them only while the block is held in reset. The first stage's chain input must be held at zero.

Top module: `sys_fir_chain`

## Requirements
- R1: Parameter NUM_MULT sets the stage count and may only be 2 or 4; any other value stops elaboration. With 2 stages the output sums two products, with 4 it sums four.
- R2: A synchronous active-high reset clears every tap, product, partial-sum and valid register. On the clock after reset `out_valid` is 0, `chain_out` is 0 and `in_ready` is 1.
- R3: After each stepping clock, `chain_out` equals the sum over k = 0..NUM_MULT-1 of coef_k times the slot taken k steps before the newest slot that has reached the output. A bubble slot counts as zero.
- R4: A sample accepted on a clock first appears as the newest term at `chain_out` exactly NUM_MULT+1 stepping clocks later.
- R5: `out_valid` is high exactly when the newest slot in the current output was an accepted sample, not a bubble.
- R6: `in_ready` is low exactly while `out_valid` is high and `out_ready` is low. While that holds, `chain_out` and `out_valid` keep their values and no sample is taken.
- R7: `cascade_in` is added into the first stage's partial sum and must stay zero outside reset.
- R8: Samples and coefficients are signed 18-bit values. The 44-bit sum never overflows, even with every operand at full-scale negative.
- R9: Coefficient k sits in bits [18k+17:18k] of `coef`. Coefficient 0 weights the newest slot of the output, and higher k weights older slots.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Block can take a sample this clock |
| in_data | input | 18 | Signed sample |
| coef | input | 18*NUM_MULT | Packed signed coefficients, coefficient k in bits [18k+17:18k] |
| cascade_in | input | 44 | Chain input of the first stage, held at zero |
| out_valid | output | 1 | `chain_out` carries a result led by a real sample |
| out_ready | input | 1 | Consumer takes the result |
| chain_out | output | 44 | Signed filter sum |

## Verification
Two things can happen on the same clock: a new sample is offered while the result at the output is being refused. The bench provokes this by driving `in_valid` and `out_ready` from independent random streams, which produces many clocks with `in_valid` high and a stalled output. A behavioural model of the slot history then checks each such clock. The offered sample must not be taken, the held result must not move, and the sample must enter on the first clock the stall lifts. Both chain lengths run side by side from the same stimulus, so each can be judged against its own history.

// File: rtl/sys_fir_pkg.sv
package sys_fir_pkg;
  localparam int SAMPLE_W = 18;
  localparam int SUM_W    = 44;
  localparam int PROD_W   = 2 * SAMPLE_W;

  typedef logic signed [SAMPLE_W-1:0] sample_t;
  typedef logic signed [PROD_W-1:0]   prod_t;
  typedef logic signed [SUM_W-1:0]    sum_t;
endpackage

// File: rtl/sys_fir_tap_line.sv
module sys_fir_tap_line
  import sys_fir_pkg::*;
#(
  parameter int NUM_MULT = 4
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    adv,
  input  sample_t din,
  output sample_t taps [NUM_MULT]
);
  // two registers per stage after the first: one for the tap, one systolic
  localparam int CHAIN_LEN = 2 * NUM_MULT - 1;

  sample_t chain_q [CHAIN_LEN];

  always_ff @(posedge clk) begin
    if (rst)      chain_q[0] <= '0;
    else if (adv) chain_q[0] <= din;
  end

  for (genvar i = 1; i < CHAIN_LEN; i++) begin : g_link
    always_ff @(posedge clk) begin
      if (rst)      chain_q[i] <= '0;
      else if (adv) chain_q[i] <= chain_q[i-1];
    end
  end

  for (genvar k = 0; k < NUM_MULT; k++) begin : g_tap
    assign taps[k] = chain_q[2*k];
  end
endmodule

// File: rtl/sys_fir_stage.sv
module sys_fir_stage
  import sys_fir_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    adv,
  input  sample_t x,
  input  sample_t c,
  input  sum_t    ps_in,
  output sum_t    ps_out
);
  prod_t prod_q;
  sum_t  prod_ext;
  sum_t  sum_nxt;
  sum_t  ps_q;

  assign prod_ext = sum_t'(prod_q);
  assign sum_nxt  = ps_in + prod_ext;

  always_ff @(posedge clk) begin
    if (rst) begin
      prod_q <= '0;
      ps_q   <= '0;
    end else if (adv) begin
      prod_q <= prod_t'(x) * prod_t'(c);
      ps_q   <= sum_nxt;
    end
  end

  assign ps_out = ps_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (adv && (ps_in[SUM_W-1] == prod_ext[SUM_W-1])) |-> (sum_nxt[SUM_W-1] == ps_in[SUM_W-1])); // R8
endmodule

// File: rtl/sys_fir_valid_pipe.sv
module sys_fir_valid_pipe #(
  parameter int DEPTH = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic adv,
  input  logic v_in,
  output logic v_out
);
  logic [DEPTH-1:0] v_q;

  always_ff @(posedge clk) begin
    if (rst)      v_q <= '0;
    else if (adv) v_q <= {v_q[DEPTH-2:0], v_in};
  end

  assign v_out = v_q[DEPTH-1];
endmodule

// File: rtl/sys_fir_chain.sv
module sys_fir_chain
  import sys_fir_pkg::*;
#(
  parameter int NUM_MULT = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         in_valid,
  output logic                         in_ready,
  input  logic [SAMPLE_W-1:0]          in_data,
  input  logic [NUM_MULT*SAMPLE_W-1:0] coef,
  input  logic [SUM_W-1:0]             cascade_in,
  output logic                         out_valid,
  input  logic                         out_ready,
  output logic [SUM_W-1:0]             chain_out
);
  // tap register + product register + sum registers along the chain
  localparam int VALID_DEPTH = NUM_MULT + 2;

  if (NUM_MULT != 2 && NUM_MULT != 4) begin : g_bad_cfg
    $error("sys_fir_chain: NUM_MULT must be 2 or 4"); // R1
  end

  logic    adv;
  sample_t din;
  sample_t taps  [NUM_MULT];
  sample_t coefs [NUM_MULT];
  sum_t    ps    [NUM_MULT+1];

  assign adv      = !(out_valid && !out_ready);
  assign in_ready = adv;
  assign din      = in_valid ? sample_t'(in_data) : '0;
  assign ps[0]    = sum_t'(cascade_in);

  sys_fir_tap_line #(.NUM_MULT(NUM_MULT)) i_taps (
    .clk (clk),
    .rst (rst),
    .adv (adv),
    .din (din),
    .taps(taps)
  );

  for (genvar k = 0; k < NUM_MULT; k++) begin : g_stage
    assign coefs[k] = sample_t'(coef[k*SAMPLE_W +: SAMPLE_W]);

    sys_fir_stage i_stage (
      .clk   (clk),
      .rst   (rst),
      .adv   (adv),
      .x     (taps[k]),
      .c     (coefs[k]),
      .ps_in (ps[k]),
      .ps_out(ps[k+1])
    );
  end

  sys_fir_valid_pipe #(.DEPTH(VALID_DEPTH)) i_vpipe (
    .clk  (clk),
    .rst  (rst),
    .adv  (adv),
    .v_in (in_valid),
    .v_out(out_valid)
  );

  assign chain_out = ps[NUM_MULT];

  AST_CASCADE_ZERO: assert property (@(posedge clk) disable iff (rst)
    cascade_in == '0); // R7

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(chain_out))); // R6

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!out_valid && chain_out == '0 && in_ready)); // R2
endmodule

// File: tb/test_sys_fir_chain.sv
`timescale 1ns/1ps
module test_sys_fir_chain;
  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               in_valid = 1'b0;
  logic signed [17:0] in_data = '0;
  logic [71:0]        coef_bus = '0;
  logic [43:0]        cascade = '0;   // R7: tied to zero throughout
  logic               out_ready = 1'b1;

  logic               rdy4, ov4, rdy2, ov2;
  logic signed [43:0] co4, co2;

  int  n_checks = 0;
  int  n_fails  = 0;
  bit  started  = 1'b0;
  string ph = "R2";

  longint mq [2][16];
  bit     mv [2][16];
  int     nm [2] = '{4, 2};
  int     coef_i [4];

  always #2 clk = ~clk;   // 250 MHz

  sys_fir_chain #(.NUM_MULT(4)) i_sys_fir_chain (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(rdy4), .in_data(in_data),
    .coef(coef_bus), .cascade_in(cascade), .out_valid(ov4), .out_ready(out_ready),
    .chain_out(co4));

  sys_fir_chain #(.NUM_MULT(2)) i_sys_fir_chain_pair (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(rdy2), .in_data(in_data),
    .coef(coef_bus[35:0]), .cascade_in(cascade), .out_valid(ov2), .out_ready(out_ready),
    .chain_out(co2));

  // behavioural reference: history of slots per instance, index 0 newest
  always @(posedge clk) begin
    started <= 1'b1;
    for (int d = 0; d < 2; d++) begin
      if (rst) begin
        for (int i = 0; i < 16; i++) begin mq[d][i] = 0; mv[d][i] = 1'b0; end
      end else if (!(mv[d][nm[d]+1] && !out_ready)) begin
        for (int i = 15; i > 0; i--) begin mq[d][i] = mq[d][i-1]; mv[d][i] = mv[d][i-1]; end
        mq[d][0] = in_valid ? longint'(in_data) : 0;
        mv[d][0] = in_valid;
      end
    end
  end

  function automatic longint exp_sum(int d);
    longint s = 0;
    for (int j = 0; j < nm[d]; j++) s += longint'(coef_i[j]) * mq[d][nm[d]+1+j];
    return s;
  endfunction

  task automatic cmp(int d, string what, longint act, longint exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s n=%0d %s: actual %0d expected %0d", ph, nm[d], what, act, exp);
    end
  endtask

  task automatic check_all();
    if (!started) return;
    for (int d = 0; d < 2; d++) begin
      bit ev = mv[d][nm[d]+1];
      cmp(d, "chain_out (R3)", d == 0 ? longint'(co4) : longint'(co2), exp_sum(d));
      cmp(d, "out_valid (R5)", d == 0 ? longint'(ov4) : longint'(ov2), longint'(ev));
      cmp(d, "in_ready (R6)",  d == 0 ? longint'(rdy4) : longint'(rdy2),
          longint'(!(ev && !out_ready)));
    end
  endtask

  task automatic drive(bit v, int data, bit r);
    @(negedge clk);
    check_all();
    in_valid  = v;
    in_data   = 18'(data);
    out_ready = r;
  endtask

  task automatic set_coefs(int c0, int c1, int c2, int c3);
    coef_i = '{c0, c1, c2, c3};
    for (int j = 0; j < 4; j++) coef_bus[j*18 +: 18] = 18'(coef_i[j]);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    drive(0, 0, 1);
    drive(0, 0, 1);
    drive(0, 0, 1);
    rst = 1'b0;
  endtask

  function automatic int rnd_s18();
    return int'($urandom_range(0, 262143)) - 131072;
  endfunction

  initial begin
    // R2: reset state
    ph = "R2";
    set_coefs(3, -5, 7, 11);
    do_reset();
    drive(0, 0, 1);

    // R9: impulse shows coefficient order
    ph = "R9";
    drive(1, 1, 1);
    for (int i = 0; i < 9; i++) drive(1, 0, 1);

    // R4: isolated impulse between bubbles, latency of NUM_MULT+1 steps
    ph = "R4";
    drive(1, 100, 1);
    for (int i = 0; i < 9; i++) drive(0, 0, 1);

    // R3 with R7 cascade tied low: random samples, consumer always ready
    ph = "R3 R7";
    for (int i = 0; i < 40; i++) drive($urandom_range(0, 3) != 0, rnd_s18(), 1);

    // R6: stalls coincide with offered samples
    ph = "R6";
    for (int i = 0; i < 200; i++) drive($urandom_range(0, 1), rnd_s18(), $urandom_range(0, 1));
    for (int i = 0; i < 8; i++) drive(0, 0, 1);

    // R5: alternating samples and bubbles
    ph = "R5";
    for (int i = 0; i < 30; i++) drive(i % 2 == 0, rnd_s18(), 1);

    // R8: full-scale operands
    ph = "R8";
    set_coefs(-131072, -131072, -131072, -131072);
    do_reset();
    for (int i = 0; i < 12; i++) drive(1, -131072, 1);
    set_coefs(131071, -131072, 131071, -131072);
    do_reset();
    for (int i = 0; i < 12; i++) drive(1, (i % 2) ? 131071 : -131072, 1);

    // R1: both stage counts on fresh coefficients with mixed back-pressure
    ph = "R1";
    set_coefs(rnd_s18(), rnd_s18(), rnd_s18(), rnd_s18());
    do_reset();
    for (int i = 0; i < 60; i++) drive($urandom_range(0, 3) != 0, rnd_s18(), $urandom_range(0, 3) != 0);
    for (int i = 0; i < 10; i++) drive(0, 0, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    #(4 * 100000);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog %s: actual hung expected done", ph);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule